// File: doc/BRIEF.md
# Memory-Mapped ATA Window Decoder

This block connects an 8-bit host memory bus, of the kind an 8088-class processor drives, to the task-file interface of an ATA drive. The drive's registers appear in host memory instead of in I/O space. A fixed window, placed just above the option ROM area, is split by one address bit into two pages. One page holds the control and status registers. The other page holds a 512-byte range in which every byte address selects the single 16-bit data register. A string-move instruction that increments its pointer can therefore stream a whole 512-byte sector, 256 words long, with no counter and no buffer in the block.

The host bus carries 8-bit accesses. For the data register, the block joins even/odd byte pairs into 16-bit drive cycles. An even-byte read runs one 16-bit drive read and keeps the upper byte, which the following odd-byte read returns. An even-byte write is held locally until the odd byte arrives, and then one 16-bit drive write sends both bytes. All other registers use single 8-bit drive cycles. The chip-select and register-address setup time, the strobe width and the hold time are parameters. The block holds a host wait signal asserted until its drive cycle has finished.

Top module: `mmio_ata_window`

## Requirements
- R1: An access whose address bits above bit 10 do not match the window base is ignored: no drive chip-select or strobe asserts, and `bus_wait` stays low.
- R2: With A10=0 and A9=0 inside the window, every value of A8..A1 selects the data register (CS0 asserted, register address 0).
- R3: With A10=0 and A9=1 inside the window, the access is ignored, as in R1.
- R4: With A10=1, A3 selects CS0 (0) or CS1 (1) and A2..A0 give the register address, whatever A9..A4 hold. Each access is one 8-bit drive cycle. A write drives DD[7:0] with the byte and DD[15:8] with zero. A read returns DD[7:0].
- R5: An even (A0=0) data read runs exactly one 16-bit drive read, returns DD[7:0] and stores DD[15:8].
- R6: An odd data read returns the stored upper byte, runs no drive cycle and completes after one wait cycle.
- R7: An even data write stores the byte, runs no drive cycle and completes after one wait cycle.
- R8: An odd data write runs one 16-bit drive write with DD = {odd byte, stored even byte}, with the output enable asserted.
- R9: In every drive cycle, chip-select and register address are asserted and stable for SETUP_CLKS clocks before the strobe. The strobe stays low for exactly PULSE_CLKS clocks. Chip-select stays asserted for HOLD_CLKS clocks after the strobe.
- R10: `bus_wait` is high from the first cycle of a decoded access until the drive cycle ends, for 1+SETUP_CLKS+PULSE_CLKS+HOLD_CLKS cycles in total. At most one of the read and write strobes is low at any time.
- R11: After reset, both strobes and both chip-selects are deasserted (high), `bus_wait` is low and the data output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | AW | Host memory address |
| bus_rd | input | 1 | Host memory read request, held until wait drops |
| bus_wr | input | 1 | Host memory write request, held until wait drops |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid once wait is low |
| bus_wait | output | 1 | Host wait, high while the access is pending |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Drive register address |
| ata_dior_n | output | 1 | Drive read strobe, active low |
| ata_diow_n | output | 1 | Drive write strobe, active low |
| ata_dd_out | output | 16 | Data to the drive |
| ata_dd_oe | output | 1 | Enable for the data driven to the drive |
| ata_dd_in | input | 16 | Data from the drive |

## Verification
The assertions check, on every cycle, the rules a drive cycle must keep: at most one strobe is low, a strobe only occurs with exactly one chip-select, address and select are stable through a drive cycle, and each strobe is exactly PULSE_CLKS long. They also check that an unmapped access or an odd data read leaves the drive untouched in the following cycle. Only the bench scenarios can show that a full sector of data reads comes back in the right byte order, that even/odd write pairs join correctly, and that the register page aliases across A9..A4 for every select and address combination.

// File: rtl/mmw_pkg.sv
`timescale 1ns/1ps
package mmw_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_DATA, TGT_REG} mmw_tgt_e;
  typedef enum logic [1:0] {CTL_IDLE, CTL_BUSY, CTL_DONE} mmw_ctl_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_STROBE, SQ_HOLD} mmw_seq_e;

  // Word sent to the drive for an access
  function automatic logic [15:0] mmw_out_word(input logic wide, input logic [7:0] hi,
                                               input logic [7:0] lo_held);
    return wide ? {hi, lo_held} : {8'h00, hi};
  endfunction
endpackage

// File: rtl/mmw_decode.sv
`timescale 1ns/1ps
module mmw_decode
  import mmw_pkg::*;
#(
  parameter int AW        = 20,
  parameter int WIN_BITS  = 11,
  parameter int DATA_BITS = 9,
  parameter logic [AW-1:0] BASE_ADDR = 20'hC8000
) (
  input  logic [AW-1:0] addr,
  output mmw_tgt_e      tgt,
  output logic          odd,
  output logic          reg_cs1,
  output logic [2:0]    reg_da
);
  localparam int PAGE_BIT = WIN_BITS - 1;

  function automatic mmw_tgt_e classify(input logic [AW-1:0] a);
    if (a[AW-1:WIN_BITS] != BASE_ADDR[AW-1:WIN_BITS]) return TGT_NONE;
    if (a[PAGE_BIT])                                  return TGT_REG;
    if (a[PAGE_BIT-1:DATA_BITS] == '0)                return TGT_DATA;
    return TGT_NONE;
  endfunction

  logic unused_mid_bits;
  assign unused_mid_bits = ^addr[DATA_BITS-1:4];

  assign tgt     = classify(addr);
  assign odd     = addr[0];
  assign reg_cs1 = addr[3];
  assign reg_da  = addr[2:0];
endmodule

// File: rtl/mmw_strobe_seq.sv
`timescale 1ns/1ps
module mmw_strobe_seq
  import mmw_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 34,
  parameter int HOLD_CLKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cs_on,
  output logic strobe_on,
  output logic cap,
  output logic fin
);
  localparam int MAXC = (SETUP_CLKS > PULSE_CLKS) ?
                        ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                        ((PULSE_CLKS > HOLD_CLKS) ? PULSE_CLKS : HOLD_CLKS);
  localparam int CW = $clog2(MAXC + 1);

  mmw_seq_e      st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] run;
  logic          last;

  assign last      = (cnt == '0);
  assign cs_on     = (st != SQ_IDLE);
  assign strobe_on = (st == SQ_STROBE);
  assign cap       = strobe_on && last;
  assign fin       = (st == SQ_HOLD) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE:   if (start) begin st <= SQ_SETUP; cnt <= CW'(SETUP_CLKS - 1); end
        SQ_SETUP:  if (last) begin st <= SQ_STROBE; cnt <= CW'(PULSE_CLKS - 1); end
                   else cnt <= cnt - 1'b1;
        SQ_STROBE: if (last) begin st <= SQ_HOLD; cnt <= CW'(HOLD_CLKS - 1); end
                   else cnt <= cnt - 1'b1;
        default:   if (last) st <= SQ_IDLE;
                   else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // strobe length observer for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (strobe_on) run <= run + 1'b1;
    else run <= '0;
  end

  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_on && run != '0) |-> (run == CW'(PULSE_CLKS)));
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && start) |-> 1'b0);
endmodule

// File: rtl/mmw_lanes.sv
`timescale 1ns/1ps
module mmw_lanes
  import mmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  wdata,
  input  logic        ld_lo,
  input  logic        ld_out,
  input  logic        out_wide,
  input  logic        cap,
  input  logic        cap_wide,
  input  logic        ret_hi,
  input  logic [15:0] dd_in,
  output logic [15:0] dd_out,
  output logic [7:0]  rdata
);
  logic [7:0] lo_held;
  logic [7:0] hi_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_held <= '0;
      hi_held <= '0;
      dd_out  <= '0;
      rdata   <= '0;
    end else begin
      if (ld_lo)  lo_held <= wdata;
      if (ld_out) dd_out  <= mmw_out_word(out_wide, wdata, lo_held);
      if (cap) begin
        rdata <= dd_in[7:0];
        if (cap_wide) hi_held <= dd_in[15:8];
      end
      if (ret_hi) rdata <= hi_held;
    end
  end
endmodule

// File: rtl/mmio_ata_window.sv
`timescale 1ns/1ps
module mmio_ata_window
  import mmw_pkg::*;
#(
  parameter int AW         = 20,
  parameter int WIN_BITS   = 11,
  parameter int DATA_BITS  = 9,
  parameter logic [AW-1:0] BASE_ADDR = 20'hC8000,
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 34,
  parameter int HOLD_CLKS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_wait,
  output logic          ata_cs0_n,
  output logic          ata_cs1_n,
  output logic [2:0]    ata_da,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [15:0]   ata_dd_out,
  output logic          ata_dd_oe,
  input  logic [15:0]   ata_dd_in
);
  mmw_tgt_e tgt;
  logic     odd, reg_cs1;
  logic [2:0] reg_da;

  mmw_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .DATA_BITS(DATA_BITS), .BASE_ADDR(BASE_ADDR))
    u_dec (.addr(bus_addr), .tgt(tgt), .odd(odd), .reg_cs1(reg_cs1), .reg_da(reg_da));

  // named events
  mmw_ctl_e ctl;
  logic req, hit, accept, need_drive, local_hi, local_lo;
  logic seq_cs, seq_strobe, seq_cap, seq_fin;
  logic cyc_rd, cyc_wide, cyc_cs1;
  logic [2:0] cyc_da;

  assign req        = bus_rd | bus_wr;
  assign hit        = (tgt != TGT_NONE);
  assign accept     = (ctl == CTL_IDLE) && req && hit;
  assign need_drive = (tgt == TGT_REG) || (bus_rd ? !odd : odd);
  assign local_hi   = accept && !need_drive && bus_rd;
  assign local_lo   = accept && !need_drive && !bus_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= CTL_IDLE;
      cyc_rd   <= 1'b0;
      cyc_wide <= 1'b0;
      cyc_cs1  <= 1'b0;
      cyc_da   <= '0;
    end else begin
      case (ctl)
        CTL_IDLE: if (accept) begin
          if (need_drive) begin
            ctl      <= CTL_BUSY;
            cyc_rd   <= bus_rd;
            cyc_wide <= (tgt == TGT_DATA);
            cyc_cs1  <= (tgt == TGT_REG) && reg_cs1;
            cyc_da   <= (tgt == TGT_REG) ? reg_da : 3'd0;
          end else begin
            ctl <= CTL_DONE;
          end
        end
        CTL_BUSY: if (seq_fin) ctl <= CTL_DONE;
        default:  if (!req) ctl <= CTL_IDLE;
      endcase
    end
  end

  mmw_strobe_seq #(.SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS), .HOLD_CLKS(HOLD_CLKS))
    u_seq (.clk(clk), .rst_n(rst_n), .start(accept && need_drive),
           .cs_on(seq_cs), .strobe_on(seq_strobe), .cap(seq_cap), .fin(seq_fin));

  mmw_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .ld_lo(local_lo), .ld_out(accept && need_drive), .out_wide(tgt == TGT_DATA),
    .cap(seq_cap && cyc_rd), .cap_wide(cyc_wide), .ret_hi(local_hi),
    .dd_in(ata_dd_in), .dd_out(ata_dd_out), .rdata(bus_rdata));

  assign bus_wait   = accept || (ctl == CTL_BUSY);
  assign ata_cs0_n  = !(seq_cs && !cyc_cs1);
  assign ata_cs1_n  = !(seq_cs && cyc_cs1);
  assign ata_da     = cyc_da;
  assign ata_dior_n = !(seq_strobe && cyc_rd);
  assign ata_diow_n = !(seq_strobe && !cyc_rd);
  assign ata_dd_oe  = seq_cs && !cyc_rd;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
  assert_strobe_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (ata_cs0_n != ata_cs1_n));
  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_BUSY && $past(ctl == CTL_BUSY)) |->
      ($stable(ata_da) && $stable(ata_cs0_n) && $stable(ata_cs1_n)));
  assert_unmapped_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_IDLE && req && !hit) |=> (ata_cs0_n && ata_cs1_n));
  assert_odd_read_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_IDLE && bus_rd && tgt == TGT_DATA && odd) |=>
      (ata_cs0_n && ata_cs1_n && !bus_wait));
endmodule

// File: tb/sim_mmio_ata_window.sv
`timescale 1ns/1ps
module sim_mmio_ata_window;
  localparam int AW = 20;
  localparam logic [AW-1:0] BASE = 20'hC8000;
  localparam int S = 2, P = 3, H = 1;
  localparam int ATA_WAITS = 1 + S + P + H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_wait, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0] ata_da;
  logic [15:0] ata_dd_out, ata_dd_in;

  always #2.5 clk = ~clk;

  mmio_ata_window #(.AW(AW), .BASE_ADDR(BASE), .SETUP_CLKS(S), .PULSE_CLKS(P), .HOLD_CLKS(H)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out),
    .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in));

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive model
  int word_idx = 0;
  function automatic logic [15:0] dev_word(input int k);
    return 16'(16'h1000 + k * 16'h0103);
  endfunction
  function automatic logic [7:0] reg_byte(input logic cs1, input logic [2:0] da);
    return 8'h40 | {4'b0, cs1, da};
  endfunction
  assign ata_dd_in = (!ata_cs0_n && ata_da == 3'd0) ? dev_word(word_idx)
                                                    : {8'hEE, reg_byte(!ata_cs1_n, ata_da)};

  // cycle monitor
  int n_cyc = 0, pre = 0, len = 0, post = 0;
  int l_pre, l_len, l_post;
  bit in_cyc = 0, seen = 0, s_wr, s_cs1, s_oe, l_wr, l_cs1, l_oe;
  logic [2:0] s_da, l_da;
  logic [15:0] s_dat, l_dat;

  always @(negedge clk) begin
    if (!ata_cs0_n || !ata_cs1_n) begin
      in_cyc = 1;
      if (!ata_dior_n || !ata_diow_n) begin
        len++;
        if (!seen) begin
          seen = 1; s_wr = !ata_diow_n; s_cs1 = !ata_cs1_n; s_da = ata_da;
          s_dat = ata_dd_out; s_oe = ata_dd_oe;
        end
      end else if (seen) post++;
      else pre++;
    end else if (in_cyc) begin
      n_cyc++;
      l_pre = pre; l_len = len; l_post = post;
      l_wr = s_wr; l_cs1 = s_cs1; l_da = s_da; l_dat = s_dat; l_oe = s_oe;
      if (!s_wr && !s_cs1 && s_da == 3'd0) word_idx++;
      in_cyc = 0; seen = 0; pre = 0; len = 0; post = 0;
    end
  end

  task automatic access(input bit rd, input logic [AW-1:0] a, input logic [7:0] wd,
                        output logic [7:0] rdat, output int waits);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = !rd; bus_wdata = wd;
    waits = 0;
    #1;
    while (bus_wait && waits < 1000) begin
      waits++;
      @(negedge clk); #1;
    end
    rdat = bus_rdata;
    bus_rd = 0; bus_wr = 0;
    @(negedge clk); @(negedge clk); #1;
  endtask

  task automatic check_timing(input string tag);
    check(l_pre == S && l_len == P && l_post == H, tag,
          {8'(l_pre), 8'(l_len), 8'(l_post)}, {8'(S), 8'(P), 8'(H)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [7:0] rd8;
    int w, c0;
    logic [15:0] expw;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n && !bus_wait && !ata_dd_oe,
          "R11 reset state", {ata_dior_n, ata_diow_n, ata_cs0_n, ata_cs1_n, bus_wait, ata_dd_oe},
          6'b111100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 outside window
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a;
      a = (i == 0) ? BASE - 1 : (i == 1) ? BASE + 20'h800 : (i == 2) ? 20'h0 : BASE ^ 20'h80000;
      c0 = n_cyc;
      access(i[0], a, 8'h5A, rd8, w);
      check(w == 0 && n_cyc == c0, "R1 unmapped ignored", w, 0);
    end
    // R3 hole A10=0, A9=1
    for (int i = 0; i < 4; i++) begin
      c0 = n_cyc;
      access(i[0], BASE + 20'h200 + AW'(i * 97), 8'h33, rd8, w);
      check(w == 0 && n_cyc == c0, "R3 hole ignored", w, 0);
    end

    // R2/R5/R6: a whole sector of word reads
    for (int k = 0; k < 256; k++) begin
      expw = dev_word(word_idx);
      c0 = n_cyc;
      access(1, BASE + AW'(2 * k), 8'h00, rd8, w);
      check(rd8 == expw[7:0], "R5 even read low byte", rd8, expw[7:0]);
      check(n_cyc == c0 + 1 && !l_wr && !l_cs1 && l_da == 3'd0, "R2 data register selected",
            {l_cs1, l_da}, 0);
      check(w == ATA_WAITS, "R10 wait length", w, ATA_WAITS);
      if (k % 32 == 0) check_timing("R9 read timing");
      c0 = n_cyc;
      access(1, BASE + AW'(2 * k + 1), 8'h00, rd8, w);
      check(rd8 == expw[15:8] && n_cyc == c0 && w == 1, "R6 odd read from latch",
            {rd8, 8'(n_cyc - c0), 8'(w)}, {expw[15:8], 8'd0, 8'd1});
    end

    // R7/R8: data writes
    for (int k = 0; k < 24; k++) begin
      logic [7:0] lo, hi;
      logic [AW-1:0] ea;
      lo = 8'(k * 37 + 5); hi = 8'(k * 11 + 200);
      ea = BASE + AW'(2 * ((k * 23) % 256));
      c0 = n_cyc;
      access(0, ea, lo, rd8, w);
      check(n_cyc == c0 && w == 1, "R7 even write held", n_cyc - c0, 0);
      access(0, ea + 1, hi, rd8, w);
      check(n_cyc == c0 + 1 && l_wr && l_oe && !l_cs1 && l_da == 3'd0 && l_dat == {hi, lo},
            "R8 odd write joined", l_dat, {hi, lo});
      if (k % 8 == 0) check_timing("R9 write timing");
    end

    // R4: register page, all selects and addresses, varying A9..A4
    for (int r = 0; r < 16; r++) begin
      logic [AW-1:0] ra;
      logic [7:0] expb;
      ra = BASE + 20'h400 + AW'(((r * 13 + 7) % 64) << 4) + AW'(r);
      c0 = n_cyc;
      access(0, ra, 8'(8'hA0 + r), rd8, w);
      check(n_cyc == c0 + 1 && l_wr && l_cs1 == r[3] && l_da == r[2:0] &&
            l_dat == {8'h00, 8'(8'hA0 + r)}, "R4 register write",
            {l_cs1, l_da, l_dat}, {r[3], r[2:0], 8'h00, 8'(8'hA0 + r)});
      expw = dev_word(word_idx);
      expb = (r[3] == 0 && r[2:0] == 0) ? expw[7:0] : reg_byte(r[3], r[2:0]);
      c0 = n_cyc;
      access(1, ra, 8'h00, rd8, w);
      check(n_cyc == c0 + 1 && !l_wr && rd8 == expb && w == ATA_WAITS, "R4 register read",
            rd8, expb);
    end
    check_timing("R9 register timing");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule